// File: doc/BRIEF.md
# Limp-Mode Clock Supervisor

This block watches the main system clock and moves the system onto an always-running backup clock. The move happens automatically when the main clock stops. It also happens when software requests it, but only once limp operation has been enabled. All control state lives in the backup clock domain, because that clock is the one that keeps running.

A divide-by-two of the main clock is synchronized into the backup domain, and an idle counter times the gaps between its edges. If no edge arrives within a fixed window of backup cycles, the main clock is declared lost. Once the block has switched, it stays on the backup clock until the next power-on reset.

A glitch-free two-clock mux produces the system clock. A second output tells the timer and real-time-clock logic which source to use. That choice is overridden while the system runs on the backup clock.

The limp-enable bit is loaded from a mode pin at power-on reset. Software can then overwrite it exactly once, and only while the backup clock is not in use.

Top module: `limp_clk_supervisor`

## Requirements
- R1: With limp enabled, once the main clock stops, `backupActive` stays 0 for at least LOSS_WINDOW-1 backup cycles and rises within LOSS_WINDOW+6 backup cycles.
- R2: A pulse on `forceWr` while `limpEnabled` is already 1 makes `backupActive` read 1 after the next rising edge of `backupClk`.
- R3: Once `backupActive` is 1 it stays 1 until the next power-on reset, even after the main clock runs again.
- R4: While `limpEnabled` is 0, neither a stopped main clock nor a `forceWr` pulse changes `backupActive`.
- R5: The first `limpWrEn` write after power-on reset loads `limpWrData` into `limpEnabled`, provided `backupActive` is 0. Every later write, and any write made while `backupActive` is 1, leaves `limpEnabled` unchanged.
- R6: During power-on reset, `limpEnabled` takes the value of `modeLimpEn`, the timer source select takes the value of `modeRtcSel`, and `backupActive` is 0.
- R7: While `backupActive` is 0, `timerSrc` is 2'b00 when the timer select is 0 (oscillator) and 2'b01 when it is 1 (external clock). A `rtcWrEn` write loads `rtcWrData` into the select.
- R8: While `backupActive` is 1, `timerSrc` is 2'b10 (backup clock), whatever the timer select holds.
- R9: Before a switch, `sysClk` follows `mainClk`. After a switch has settled, `sysClk` follows `backupClk` and shows no main-clock pulses, whether the main clock is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| mainClk | input | 1 | Main system clock under supervision |
| backupClk | input | 1 | Always-running backup clock; clocks all control state |
| modeLimpEn | input | 1 | Mode pin giving the limp-enable value during reset |
| modeRtcSel | input | 1 | Mode pin giving the timer source select during reset |
| limpWrEn | input | 1 | Write strobe for the limp-enable bit |
| limpWrData | input | 1 | Value written to the limp-enable bit |
| forceWr | input | 1 | Software request to switch to the backup clock |
| rtcWrEn | input | 1 | Write strobe for the timer source select |
| rtcWrData | input | 1 | Value written to the timer source select |
| sysClk | output | 1 | Glitch-free selected system clock |
| backupActive | output | 1 | 1 when the system clock is the backup clock |
| limpEnabled | output | 1 | Current limp-enable bit |
| timerSrc | output | 2 | Timer/RTC source: 00 oscillator, 01 external, 10 backup |

## Verification
The hardest situation to reach is a loss of the main clock that is detected while another clock is still driving `sysClk`. Reaching it requires the main clock to stop entirely, not just slow down, and the handover has to finish without a live main clock to acknowledge it.

The bench gates its own main-clock generator low at a backup-clock edge. It then brackets the detection time from both sides. Next it restarts the main clock and confirms that the system neither switches back nor lets main-clock pulses leak onto `sysClk`.

The write-once lock is reached by separate power-on resets with different mode-pin values. Each reset starts a fresh write budget.

// File: rtl/limp_clk_pkg.sv
package limp_clk_pkg;

  typedef struct packed {
    logic loadLimp;
    logic loadRtc;
    logic goBackup;
    logic lossSwitch;
    logic detRun;
  } strobe_t;

endpackage

// File: rtl/limp_clk_ctrl.sv
module limp_clk_ctrl
  import limp_clk_pkg::*;
(
  input  logic    limpWrEn,
  input  logic    forceWr,
  input  logic    rtcWrEn,
  input  logic    limpEn,
  input  logic    written,
  input  logic    onBackup,
  input  logic    lossSeen,
  output strobe_t stb
);

  always_comb begin
    stb.loadLimp   = limpWrEn & ~written & ~onBackup;
    stb.loadRtc    = rtcWrEn;
    stb.detRun     = limpEn & ~onBackup;
    stb.lossSwitch = limpEn & ~onBackup & lossSeen;
    stb.goBackup   = limpEn & ~onBackup & (forceWr | lossSeen);
  end

endmodule

// File: rtl/limp_clk_datapath.sv
module limp_clk_datapath
  import limp_clk_pkg::*;
#(
  parameter int LOSS_WINDOW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mainClk,
  input  logic       backupClk,
  input  logic       porRstN,
  input  logic       modeLimpEn,
  input  logic       modeRtcSel,
  input  logic       limpWrData,
  input  logic       rtcWrData,
  input  strobe_t    stb,
  output logic       limpEn,
  output logic       written,
  output logic       onBackup,
  output logic       killMain,
  output logic       lossSeen,
  output logic [1:0] timerSrc
);

  localparam int CW = (LOSS_WINDOW > 2) ? $clog2(LOSS_WINDOW) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_WINDOW - 1);

  logic                   mainDiv2;
  logic [SYNC_STAGES-1:0] divSync;
  logic                   divPrev;
  logic                   edgeSeen;
  logic [CW-1:0]          idleCnt;
  logic                   rtcSel;

  // toggle flop in the main domain; its edges are the activity signal
  always_ff @(posedge mainClk or negedge porRstN) begin
    if (!porRstN) mainDiv2 <= 1'b0;
    else          mainDiv2 <= ~mainDiv2;
  end

  always_ff @(posedge backupClk or negedge porRstN) begin
    if (!porRstN) begin
      divSync <= '0;
      divPrev <= 1'b0;
    end else begin
      divSync <= {divSync[SYNC_STAGES-2:0], mainDiv2};
      divPrev <= divSync[SYNC_STAGES-1];
    end
  end

  assign edgeSeen = divSync[SYNC_STAGES-1] ^ divPrev;

  always_ff @(posedge backupClk or negedge porRstN) begin
    if (!porRstN)                   idleCnt <= '0;
    else if (!stb.detRun || edgeSeen) idleCnt <= '0;
    else if (idleCnt != LIMIT)        idleCnt <= idleCnt + 1'b1;
  end

  assign lossSeen = stb.detRun & ~edgeSeen & (idleCnt == LIMIT);

  // control/status slice; mode pins load while reset is held
  always_ff @(posedge backupClk or negedge porRstN) begin
    if (!porRstN) begin
      limpEn   <= modeLimpEn;
      rtcSel   <= modeRtcSel;
      written  <= 1'b0;
      onBackup <= 1'b0;
      killMain <= 1'b0;
    end else begin
      if (stb.loadLimp) begin
        limpEn  <= limpWrData;
        written <= 1'b1;
      end
      if (stb.loadRtc)    rtcSel   <= rtcWrData;
      if (stb.goBackup)   onBackup <= 1'b1;
      if (stb.lossSwitch) killMain <= 1'b1;
    end
  end

  always_comb begin
    if (onBackup) timerSrc = 2'b10;
    else          timerSrc = {1'b0, rtcSel};
  end

endmodule

// File: rtl/limp_clk_mux.sv
module limp_clk_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic mainClk,
  input  logic backupClk,
  input  logic porRstN,
  input  logic selBackup,
  input  logic killMain,
  output logic sysClk
);

  logic [SYNC_STAGES-1:0] mainSel;
  logic [SYNC_STAGES-1:0] mainOffSync;
  logic [SYNC_STAGES-1:0] backupSel;
  logic                   mainEnQ;
  logic                   backupEnQ;
  logic                   mainRstN;
  logic                   mainGone;

  // a dead main clock cannot retire its own enable; clear it asynchronously
  assign mainRstN = porRstN & ~killMain;

  always_ff @(negedge mainClk or negedge mainRstN) begin
    if (!mainRstN) mainSel <= '0;
    else           mainSel <= {mainSel[SYNC_STAGES-2:0], ~selBackup};
  end

  assign mainEnQ = mainSel[SYNC_STAGES-1];

  always_ff @(negedge backupClk or negedge porRstN) begin
    if (!porRstN) mainOffSync <= '0;
    else          mainOffSync <= {mainOffSync[SYNC_STAGES-2:0], ~mainEnQ};
  end

  assign mainGone = killMain | mainOffSync[SYNC_STAGES-1];

  always_ff @(negedge backupClk or negedge porRstN) begin
    if (!porRstN) backupSel <= '0;
    else          backupSel <= {backupSel[SYNC_STAGES-2:0], selBackup & mainGone};
  end

  assign backupEnQ = backupSel[SYNC_STAGES-1];

  assign sysClk = (mainClk & mainEnQ) | (backupClk & backupEnQ);

endmodule

// File: rtl/limp_clk_supervisor.sv
module limp_clk_supervisor
  import limp_clk_pkg::*;
#(
  parameter int LOSS_WINDOW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       porRstN,
  input  logic       mainClk,
  input  logic       backupClk,
  input  logic       modeLimpEn,
  input  logic       modeRtcSel,
  input  logic       limpWrEn,
  input  logic       limpWrData,
  input  logic       forceWr,
  input  logic       rtcWrEn,
  input  logic       rtcWrData,
  output logic       sysClk,
  output logic       backupActive,
  output logic       limpEnabled,
  output logic [1:0] timerSrc
);

  strobe_t stb;
  logic    limpEn;
  logic    written;
  logic    onBackup;
  logic    killMain;
  logic    lossSeen;

  limp_clk_ctrl ctrl_i (
    .limpWrEn (limpWrEn),
    .forceWr  (forceWr),
    .rtcWrEn  (rtcWrEn),
    .limpEn   (limpEn),
    .written  (written),
    .onBackup (onBackup),
    .lossSeen (lossSeen),
    .stb      (stb)
  );

  limp_clk_datapath #(
    .LOSS_WINDOW (LOSS_WINDOW),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .mainClk    (mainClk),
    .backupClk  (backupClk),
    .porRstN    (porRstN),
    .modeLimpEn (modeLimpEn),
    .modeRtcSel (modeRtcSel),
    .limpWrData (limpWrData),
    .rtcWrData  (rtcWrData),
    .stb        (stb),
    .limpEn     (limpEn),
    .written    (written),
    .onBackup   (onBackup),
    .killMain   (killMain),
    .lossSeen   (lossSeen),
    .timerSrc   (timerSrc)
  );

  limp_clk_mux #(
    .SYNC_STAGES (SYNC_STAGES)
  ) mux_i (
    .mainClk   (mainClk),
    .backupClk (backupClk),
    .porRstN   (porRstN),
    .selBackup (onBackup),
    .killMain  (killMain),
    .sysClk    (sysClk)
  );

  assign backupActive = onBackup;
  assign limpEnabled  = limpEn;

endmodule

// File: rtl/limp_clk_supervisor_chk.sv
module limp_clk_supervisor_chk (
  input logic       backupClk,
  input logic       porRstN,
  input logic       forceWr,
  input logic       limpWrEn,
  input logic       backupActive,
  input logic       limpEnabled,
  input logic [1:0] timerSrc
);

  a_r3_backup_sticky: assert property (@(posedge backupClk) disable iff (!porRstN)
    backupActive |=> backupActive);

  a_r4_disabled_holds: assert property (@(posedge backupClk) disable iff (!porRstN)
    (!limpEnabled && !backupActive) |=> !backupActive);

  a_r2_force_switch: assert property (@(posedge backupClk) disable iff (!porRstN)
    (forceWr && limpEnabled && !backupActive) |=> backupActive);

  a_r5_locked_on_backup: assert property (@(posedge backupClk) disable iff (!porRstN)
    (backupActive && limpWrEn) |=> $stable(limpEnabled));

  a_r8_timer_backup: assert property (@(posedge backupClk) disable iff (!porRstN)
    backupActive |-> (timerSrc == 2'b10));

  a_r7_timer_select: assert property (@(posedge backupClk) disable iff (!porRstN)
    !backupActive |-> (timerSrc != 2'b10 && timerSrc != 2'b11));

endmodule

bind limp_clk_supervisor limp_clk_supervisor_chk chk_i (.*);

// File: tb/limp_clk_supervisor_tb_top.sv
`timescale 1ns/1ps
module limp_clk_supervisor_tb_top;

  localparam int W = 16;

  logic porRstN = 1'b0;
  logic mainClk = 1'b0;
  logic backupClk = 1'b0;
  logic mainRun = 1'b1;
  logic modeLimpEn = 1'b0, modeRtcSel = 1'b0;
  logic limpWrEn = 1'b0, limpWrData = 1'b0, forceWr = 1'b0;
  logic rtcWrEn = 1'b0, rtcWrData = 1'b0;
  logic sysClk, backupActive, limpEnabled;
  logic [1:0] timerSrc;

  int checks = 0;
  int fails = 0;
  bit mask = 1'b0;
  bit mLimp, mRtc, mWritten, mBk;

  limp_clk_supervisor #(.LOSS_WINDOW(W)) dut_i (
    .porRstN(porRstN), .mainClk(mainClk), .backupClk(backupClk),
    .modeLimpEn(modeLimpEn), .modeRtcSel(modeRtcSel),
    .limpWrEn(limpWrEn), .limpWrData(limpWrData), .forceWr(forceWr),
    .rtcWrEn(rtcWrEn), .rtcWrData(rtcWrData),
    .sysClk(sysClk), .backupActive(backupActive),
    .limpEnabled(limpEnabled), .timerSrc(timerSrc)
  );

  always #10 backupClk = ~backupClk;
  always begin
    #6;
    mainClk = mainRun ? ~mainClk : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each backup edge
  always @(posedge backupClk) begin
    if (!porRstN) begin
      mLimp = modeLimpEn; mRtc = modeRtcSel; mWritten = 0; mBk = 0;
    end else if (!mask) begin
      if (forceWr && mLimp) mBk = 1;
      if (limpWrEn && !mWritten && !mBk) begin
        mLimp = limpWrData; mWritten = 1;
      end
      if (rtcWrEn) mRtc = rtcWrData;
    end
  end

  always @(negedge backupClk) begin
    if (porRstN && !mask) begin
      chk(limpEnabled == mLimp, "R5 model limpEnabled", limpEnabled, mLimp);
      chk(backupActive == mBk, "R2 model backupActive", backupActive, mBk);
      chk(timerSrc == (mBk ? 2'd2 : {1'b0, mRtc}), "R7 model timerSrc", timerSrc,
          mBk ? 2 : int'(mRtc));
    end
  end

  task automatic por(input bit limpPin, input bit rtcPin);
    @(negedge backupClk); #1;
    porRstN = 0; modeLimpEn = limpPin; modeRtcSel = rtcPin; mainRun = 1;
    repeat (3) @(negedge backupClk);
    #1;
    chk(limpEnabled == limpPin, "R6 reset limp", limpEnabled, limpPin);
    chk(timerSrc == {1'b0, rtcPin}, "R6 reset timer", timerSrc, rtcPin);
    chk(backupActive == 0, "R6 reset backup", backupActive, 0);
    porRstN = 1;
    repeat (2) @(negedge backupClk);
  endtask

  task automatic wrLimp(input bit v);
    @(negedge backupClk); #1; limpWrEn = 1; limpWrData = v;
    @(negedge backupClk); #1; limpWrEn = 0;
  endtask

  task automatic wrRtc(input bit v);
    @(negedge backupClk); #1; rtcWrEn = 1; rtcWrData = v;
    @(negedge backupClk); #1; rtcWrEn = 0;
  endtask

  task automatic pulseForce();
    @(negedge backupClk); #1; forceWr = 1;
    @(negedge backupClk); #1; forceWr = 0;
  endtask

  task automatic stopMain(input bit expectSwitch);
    @(negedge backupClk); mainRun = 0; mask = expectSwitch;
    repeat (W - 1) @(negedge backupClk);
    #1;
    chk(backupActive == 0, "R1 too early", backupActive, 0);
    repeat (7) @(negedge backupClk);
    #1;
    if (expectSwitch) chk(backupActive == 1, "R1 late", backupActive, 1);
    else              chk(backupActive == 0, "R4 loss ignored", backupActive, 0);
    if (expectSwitch) mBk = 1;
    mask = 0;
  endtask

  task automatic checkMux(input bit expectBackup, input string req);
    repeat (12) @(negedge backupClk);
    for (int i = 0; i < 4; i++) begin
      @(posedge backupClk); #3;
      if (expectBackup) chk(sysClk == 1, req, sysClk, 1);
      else              chk(sysClk == mainClk, req, sysClk, mainClk);
      for (int k = 0; k < 3; k++) begin
        #4;
        if (expectBackup) chk(sysClk == backupClk, req, sysClk, backupClk);
        else              chk(sysClk == mainClk, req, sysClk, mainClk);
      end
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // limp disabled from the pins
    por(0, 0);
    wrRtc(1);
    #1 chk(timerSrc == 2'b01, "R7 external select", timerSrc, 1);
    pulseForce();
    #1 chk(backupActive == 0, "R4 force ignored", backupActive, 0);
    stopMain(0);
    @(negedge backupClk); mainRun = 1;
    wrLimp(1);
    #1 chk(limpEnabled == 1, "R5 first write", limpEnabled, 1);
    wrLimp(0);
    #1 chk(limpEnabled == 1, "R5 second write ignored", limpEnabled, 1);
    checkMux(0, "R9 main path");
    pulseForce();
    #1 chk(backupActive == 1, "R2 forced switch", backupActive, 1);
    chk(timerSrc == 2'b10, "R8 backup override", timerSrc, 2);
    wrRtc(0);
    #1 chk(timerSrc == 2'b10, "R8 select ignored", timerSrc, 2);
    checkMux(1, "R9 backup path main running");

    // limp enabled from the pins, automatic loss switch
    por(1, 1);
    chk(timerSrc == 2'b01, "R7 pin external", timerSrc, 1);
    stopMain(1);
    chk(timerSrc == 2'b10, "R8 after loss", timerSrc, 2);
    checkMux(1, "R9 backup path main dead");
    @(negedge backupClk); mainRun = 1;
    repeat (3 * W) @(negedge backupClk);
    #1 chk(backupActive == 1, "R3 no switch back", backupActive, 1);
    wrLimp(0);
    #1 chk(limpEnabled == 1, "R5 write on backup ignored", limpEnabled, 1);
    checkMux(1, "R3 R9 main restarted");

    // software disables limp with its single write
    por(1, 0);
    wrLimp(0);
    #1 chk(limpEnabled == 0, "R5 disable write", limpEnabled, 0);
    wrLimp(1);
    #1 chk(limpEnabled == 0, "R5 relock", limpEnabled, 0);
    pulseForce();
    #1 chk(backupActive == 0, "R4 force after disable", backupActive, 0);
    chk(timerSrc == 2'b00, "R7 oscillator", timerSrc, 0);

    repeat (4) @(negedge backupClk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule